// File: doc/BRIEF.md
# Sampled-Clock Parallel-to-Serial Shift Register

This block is an eight-stage register that is loaded in parallel and emptied serially. It runs on a fast system clock. It watches two slow external clock-type lines, a shift clock and an inhibit. Each line passes through its own synchroniser. A shift happens on a rising edge of the OR of the two synchronised lines. Because of this, either line can act as the shift clock while the other is held low, and a line that is held high blocks the other line.

A level-sensitive, active-low load select overrides shifting. While the select is low, every stage copies the parallel input bus. While it is high, each detected shift edge moves the contents one stage toward the output end and takes the serial input into the first stage. The true output always shows the last stage and the complementary output shows its inverse. To build a longer chain, one device's output drives the next device's serial input.

Top module: `pso_shifter`

## Requirements
- R1: While `load_n` is low, at every system clock edge all stages copy `par_in` (bit 0 goes to the first stage, bit WIDTH-1 goes to the last stage). This happens whatever the levels of `sclk_in` and `inh_in`.
- R2: With `load_n` high and `sclk_in` held high, pulses on `inh_in` leave the contents unchanged.
- R3: With `load_n` high and `inh_in` held high, pulses on `sclk_in` leave the contents unchanged.
- R4: With `load_n` high, a low-to-high change on either `sclk_in` or `inh_in` while the other is low causes exactly one shift. A line level sampled at system edge n triggers the shift at edge n+2.
- R5: On a shift, each stage takes the value of the stage before it, and the first stage takes `ser_in` as sampled at the shift edge.
- R6: `q_out` always equals the last stage, and `q_out_n` is always its inverse.
- R7: The stages other than the last have no direct effect on the outputs. Two loads that differ only in those stages give the same output.
- R8: If `load_n` is low at the system edge where a shift edge is detected, the load takes effect and that shift edge is discarded.
- R9: While `rst_n` is low at a system clock edge, all stages and the edge-detection state clear to zero, so `q_out` is 0 and `q_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_n | input | 1 | Low: parallel load; high: shift allowed |
| par_in | input | WIDTH | Parallel data, bit 0 to the first stage |
| ser_in | input | 1 | Serial data into the first stage |
| sclk_in | input | 1 | External shift clock, asynchronous |
| inh_in | input | 1 | External clock inhibit, asynchronous |
| q_out | output | 1 | Last stage |
| q_out_n | output | 1 | Inverse of the last stage |

## Verification
The bench drives the inhibit line as the shift clock on alternate shifts. A design that treats inhibit only as a gate would then stall, and one that shifts on falling edges would drop bits. With one line held high, it pulses the other line repeatedly and then shifts the whole contents out. A design that shifts on either line's own edge, and not on the OR, would show misordered bits. It pulses load for exactly the system cycle in which a shift edge lands. A design that lets the shift win, or that replays the edge after the load, would output the loaded byte displaced by one bit. A behavioural model compares both outputs on every cycle, which also catches an off-by-one synchroniser latency.

// File: rtl/pso_pkg.sv
package pso_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_SHIFT = 2'd2
  } pso_act_e;

  // Load has priority over a detected shift edge.
  function automatic pso_act_e pick_action(input logic load_n, input logic edge_evt);
    if (!load_n)       return ACT_LOAD;
    else if (edge_evt) return ACT_SHIFT;
    else               return ACT_HOLD;
  endfunction
endpackage

// File: rtl/pso_sync.sv
module pso_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_sync
);
  logic [DEPTH-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[DEPTH-1];
endmodule

// File: rtl/pso_edge.sv
module pso_edge #(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic inh_in,
  output logic edge_evt
);
  logic sclk_s;
  logic inh_s;
  logic or_now;
  logic or_prev_q;

  pso_sync #(.DEPTH(SYNC_DEPTH)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_in(sclk_in), .q_sync(sclk_s)
  );
  pso_sync #(.DEPTH(SYNC_DEPTH)) u_sync_inh (
    .clk(clk), .rst_n(rst_n), .d_in(inh_in), .q_sync(inh_s)
  );

  // A high level on either line masks the other, so only the OR can rise.
  assign or_now = sclk_s | inh_s;

  always_ff @(posedge clk) begin
    if (!rst_n) or_prev_q <= 1'b0;
    else        or_prev_q <= or_now;
  end

  assign edge_evt = or_now & ~or_prev_q;
endmodule

// File: rtl/pso_stages.sv
module pso_stages
  import pso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pso_act_e         act,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] stages
);
  localparam int unsigned LAST = WIDTH - 1;

  function automatic logic [WIDTH-1:0] shift_in(input logic [WIDTH-1:0] cur, input logic s);
    return {cur[LAST-1:0], s};
  endfunction

  logic [WIDTH-1:0] stages_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stages_q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD:  stages_q <= par_in;
        ACT_SHIFT: stages_q <= shift_in(stages_q, ser_in);
        default:   stages_q <= stages_q;
      endcase
    end
  end

  assign stages = stages_q;
endmodule

// File: rtl/pso_shifter.sv
module pso_shifter
  import pso_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  input  logic             sclk_in,
  input  logic             inh_in,
  output logic             q_out,
  output logic             q_out_n
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             edge_evt;
  logic             shift_evt;
  logic             load_evt;
  pso_act_e         act;
  logic [WIDTH-1:0] stages;

  pso_edge #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .inh_in(inh_in), .edge_evt(edge_evt)
  );

  assign act       = pick_action(load_n, edge_evt);
  assign shift_evt = (act == ACT_SHIFT);
  assign load_evt  = (act == ACT_LOAD);

  pso_stages #(.WIDTH(WIDTH)) u_stages (
    .clk(clk), .rst_n(rst_n), .act(act), .par_in(par_in), .ser_in(ser_in), .stages(stages)
  );

  assign q_out   = stages[LAST];
  assign q_out_n = ~stages[LAST];

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> stages == $past(par_in)) else $error("load mismatch"); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !shift_evt) |=> $stable(stages)) else $error("idle change"); // R2

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (stages[0] == $past(ser_in)) && (stages[LAST] == $past(stages[LAST-1])))
    else $error("shift order"); // R5

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && !load_n) |=> q_out == $past(par_in[LAST])) else $error("load lost"); // R8

  AST_OUT_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
    q_out != q_out_n) else $error("outputs not complementary"); // R6
endmodule

// File: tb/pso_shifter_tb_top.sv
`timescale 1ns/1ps
module pso_shifter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [7:0] par_in = 8'h00;
  logic       ser_in = 1'b0;
  logic       sclk_in = 1'b0;
  logic       inh_in = 1'b0;
  logic       q_out;
  logic       q_out_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  pso_shifter #(.WIDTH(8), .SYNC_DEPTH(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .par_in(par_in), .ser_in(ser_in),
    .sclk_in(sclk_in), .inh_in(inh_in), .q_out(q_out), .q_out_n(q_out_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: bit queue of stages (index 0 first stage), queue of sampled OR levels.
  bit mq[$];
  bit orq[$];
  initial begin
    for (int i = 0; i < 8; i++) mq.push_back(1'b0);
    for (int i = 0; i < 4; i++) orq.push_back(1'b0);
  end

  always @(posedge clk) begin
    bit lvl;
    bit fire;
    lvl = rst_n ? (sclk_in | inh_in) : 1'b0;
    orq.push_front(lvl);
    void'(orq.pop_back());
    fire = orq[2] && !orq[3];
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) mq[i] = 1'b0;
    end else if (!load_n) begin
      for (int i = 0; i < 8; i++) mq[i] = par_in[i];
    end else if (fire) begin
      mq.push_front(ser_in);
      void'(mq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(q_out === mq[7], "R6 model q_out", int'(q_out), int'(mq[7]));
      chk(q_out_n === !mq[7], "R6 model q_out_n", int'(q_out_n), int'(!mq[7]));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [7:0] b);
    par_in = b; load_n = 1'b0; tick(1); load_n = 1'b1; tick(1);
  endtask

  task automatic pulse(input bit use_inh);
    if (use_inh) inh_in = 1'b1; else sclk_in = 1'b1;
    tick(4);
    if (use_inh) inh_in = 1'b0; else sclk_in = 1'b0;
    tick(4);
  endtask

  // Shift a loaded byte out, feed sers behind it, and check both appear in order.
  task automatic shift_out(input logic [7:0] b, input logic [7:0] sers, input string tag);
    for (int k = 0; k < 8; k++) begin
      chk(q_out === b[7-k], tag, int'(q_out), int'(b[7-k]));
      ser_in = sers[k];
      pulse(k[0]);
    end
    for (int k = 0; k < 8; k++) begin
      chk(q_out === sers[k], {tag, " serial-in follow R5"}, int'(q_out), int'(sers[k]));
      ser_in = 1'b0;
      pulse(!k[0]);
    end
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] b2;
    logic [7:0] s;
    tick(3);
    chk(q_out === 1'b0, "R9 reset q_out", int'(q_out), 0);
    chk(q_out_n === 1'b1, "R9 reset q_out_n", int'(q_out_n), 1);
    rst_n = 1'b1;
    model_on = 1'b1;
    tick(2);

    // R1: load while both clock-type lines are high
    sclk_in = 1'b1; inh_in = 1'b1; tick(4);
    do_load(8'hA5);
    chk(q_out === 1'b1, "R1 load with lines high", int'(q_out), 1);
    sclk_in = 1'b0; inh_in = 1'b0; tick(4);
    shift_out(8'hA5, 8'h3C, "R1 loaded content");

    // R4 R5: random bytes, alternating sclk / inhibit as the clock
    for (int t = 0; t < 4; t++) begin
      b = 8'($urandom); s = 8'($urandom);
      do_load(b);
      shift_out(b, s, "R4 shift order");
    end

    // R7: lower stages do not reach the outputs
    do_load(8'h80);
    chk(q_out === 1'b1, "R7 last stage only", int'(q_out), 1);
    do_load(8'hFF);
    chk(q_out === 1'b1, "R7 last stage only", int'(q_out), 1);
    do_load(8'h7F);
    chk(q_out === 1'b0, "R7 last stage only", int'(q_out), 0);
    do_load(8'h00);
    chk(q_out === 1'b0, "R7 last stage only", int'(q_out), 0);

    // R2: sclk held high, inhibit pulses have no effect
    sclk_in = 1'b1; tick(4);
    b = 8'h96; do_load(b);
    for (int p = 0; p < 3; p++) pulse(1'b1);
    chk(q_out === b[7], "R2 sclk high hold", int'(q_out), int'(b[7]));
    sclk_in = 1'b0; tick(4);
    shift_out(b, 8'hC3, "R2 contents kept");

    // R3: inhibit held high, sclk pulses have no effect
    inh_in = 1'b1; tick(4);
    b = 8'h5A; do_load(b);
    for (int p = 0; p < 3; p++) pulse(1'b0);
    chk(q_out === b[7], "R3 inhibit high hold", int'(q_out), int'(b[7]));
    inh_in = 1'b0; tick(4);
    shift_out(b, 8'h81, "R3 contents kept");

    // R8: load low exactly at the shift-edge cycle
    b = 8'h01; do_load(b);
    b2 = 8'hB4; par_in = b2;
    sclk_in = 1'b1; tick(1); tick(1);
    load_n = 1'b0; tick(1); load_n = 1'b1;
    tick(4); sclk_in = 1'b0; tick(4);
    chk(q_out === b2[7], "R8 load beats shift", int'(q_out), int'(b2[7]));
    shift_out(b2, 8'h6E, "R8 no replayed shift");

    // R9: reset mid-stream clears contents
    do_load(8'hFF);
    rst_n = 1'b0; tick(2);
    chk(q_out === 1'b0, "R9 reset clears", int'(q_out), 0);
    rst_n = 1'b1; tick(2);
    shift_out(8'h00, 8'hF0, "R9 cleared content");

    model_on = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule